// File: doc/BRIEF.md
# Receive performance monitor counters for a DS1/E1 link

This block keeps the receive-side error and event counts for one DS1 or E1 link. It sits behind a framer and takes one-cycle event strobes from it:
- framing-word comparison results;
- the bit-2 value of frames that carry no alignment word;
- CRC check outcomes;
- received E bits;
- Sa6 bits tagged with their slot inside a CRC-4 sub-multiframe;
- two alignment flags, one for frame alignment and one for CRC multiframe alignment.

Five 16-bit saturating counters are held. Each counter only advances while the alignment state that gives its event meaning is held.

The host reads a counter through a small request/response stream. A request carries a counter selector. It is accepted on a clock edge where `rd_req_valid` and `rd_req_ready` are both high. At that same edge the selected counter value is captured into the response register and the counter is cleared. The response stays on `rsp_data` with `rsp_valid` high until the edge where `rsp_ready` is high. A new request is accepted only when the response register is empty or is being drained in that same cycle. Configuration and alignment inputs are plain levels.

Top module: `pm_link_counters`

## Requirements
- R1: After reset every counter reads 0, `rsp_valid` is 0 and `rd_req_ready` is 1.
- R2: A read returns the value the selected counter held at the accepting edge and clears that counter. Selector encodings: 0 framing errors, 1 CRC errors, 2 E-bit zeros, 3 Sa6 pattern 0,0,x,1, 4 Sa6 pattern 0,0,1,x. Selectors 5 to 7 return 0.
- R3: A `fw_valid` strobe with any nonzero bit in the mismatch vector `fw_err` adds exactly 1 to the framing counter, whatever the number of mismatched bits. The strobe adds nothing while `frame_ok` is 0.
- R4: In E1 mode with `nf_chk_en`=1, an `nf_valid` strobe with `nf_bit2`=0 adds 1 to the framing counter, subject to the same `frame_ok` gate. With `nf_chk_en`=0 or in DS1 mode the strobe has no effect.
- R5: A `crc_valid` strobe with `crc_err`=1 adds 1 to the CRC counter, but only while `mf_ok` is 1.
- R6: In E1 mode an `ebit_valid` strobe with `ebit`=0 adds 1 to the E-bit counter, but only while `mf_ok` is 1.
- R7: Sa6 bits arrive on `sa6_valid` with slot `sa6_slot` 0..3. They form a nibble whose slot-0 bit is the MSB. A nibble is evaluated once, on its slot-3 bit, and only if slots 0, 1 and 2 arrived in order before it. The nibble adds 1 to the first Sa6 counter when it matches 0,0,x,1 and 1 to the second when it matches 0,0,1,x. A value of 0011 adds to both. No nibble counts while `mf_ok` is 0 or in DS1 mode.
- R8: Counters stop at 0xFFFF instead of wrapping.
- R9: When an event and a read of the same counter fall on one edge, the read returns the old value and the counter becomes 1.
- R10: In DS1 mode (`e1_mode`=0) the E-bit and both Sa6 counters are held at 0.
- R11: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_data` is held and `rd_req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e1_mode | input | 1 | 1 = E1 operation, 0 = DS1 |
| nf_chk_en | input | 1 | Also count bit-2 errors of non-alignment frames |
| frame_ok | input | 1 | Frame alignment held |
| mf_ok | input | 1 | CRC multiframe alignment held |
| fw_valid | input | 1 | Framing word compared this cycle |
| fw_err | input | 7 | Per-bit mismatch of the framing word |
| nf_valid | input | 1 | Non-alignment frame bit 2 present |
| nf_bit2 | input | 1 | Received bit 2 of that frame |
| crc_valid | input | 1 | CRC check result present |
| crc_err | input | 1 | CRC check failed |
| ebit_valid | input | 1 | E bit present |
| ebit | input | 1 | Received E bit |
| sa6_valid | input | 1 | Sa6 bit present |
| sa6_slot | input | 2 | Slot of the Sa6 bit in its sub-multiframe |
| sa6_bit | input | 1 | Received Sa6 bit |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read request can be accepted |
| rd_req_sel | input | 3 | Counter selector |
| rsp_valid | output | 1 | Response holds a counter value |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 16 | Counter value read |

## Verification
Framing words are driven with one, two and three mismatched bits, so that a design that counts mismatched bits is told apart from one that counts words. Each counter class is then driven once with its alignment flag dropped, which exposes a counter gated by the wrong flag. Sa6 nibbles 0001, 0010, 0011, 0101 and 1001 cover the single-match, double-match and no-match cases, and a nibble that starts at slot 1 shows that an incomplete nibble is ignored. Long runs of CRC errors reach saturation. A read on the same edge as an event, and a read held back by `rsp_ready`, cover the read port's corner cases.

// File: rtl/pm_cnt_pkg.sv
package pm_cnt_pkg;
  localparam int CNT_W   = 16;
  localparam int NUM_CNT = 5;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_FRM  = 3'd0,
    SEL_CRC  = 3'd1,
    SEL_EBIT = 3'd2,
    SEL_SA6A = 3'd3,
    SEL_SA6B = 3'd4
  } cnt_sel_e;
endpackage

// File: rtl/pm_sat_counter.sv
module pm_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_zero,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || hold_zero) value <= '0;
    else if (clr)            value <= inc ? W'(1) : '0;
    else if (inc && value != MAXV) value <= value + W'(1);
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (value == MAXV && inc && !clr && !hold_zero) |=> value == MAXV);

  // R9
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc && !hold_zero) |=> value == W'(1));
endmodule

// File: rtl/pm_sa6_nibble.sv
module pm_sa6_nibble (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       bit_valid,
  input  logic [1:0] slot,
  input  logic       bit_in,
  output logic       hit_a,
  output logic       hit_b
);
  logic [2:0] sh;
  logic [1:0] got;
  logic       done;
  logic [3:0] nib;

  assign done = enable && bit_valid && slot == 2'd3 && got == 2'd3;
  assign nib  = {sh, bit_in};
  assign hit_a = done && nib[3:2] == 2'b00 && nib[0];
  assign hit_b = done && nib[3:1] == 3'b001;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      sh  <= '0;
      got <= '0;
    end else if (bit_valid) begin
      if (slot == 2'd0) begin
        sh  <= {2'b00, bit_in};
        got <= 2'd1;
      end else if (slot == got && slot != 2'd3) begin
        sh  <= {sh[1:0], bit_in};
        got <= got + 2'd1;
      end else begin
        got <= '0;
      end
    end
  end

  // R7
  sa6_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(hit_a || hit_b));
endmodule

// File: rtl/pm_link_counters.sv
module pm_link_counters
  import pm_cnt_pkg::*;
#(
  parameter int FW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             e1_mode,
  input  logic             nf_chk_en,
  input  logic             frame_ok,
  input  logic             mf_ok,
  input  logic             fw_valid,
  input  logic [FW_W-1:0]  fw_err,
  input  logic             nf_valid,
  input  logic             nf_bit2,
  input  logic             crc_valid,
  input  logic             crc_err,
  input  logic             ebit_valid,
  input  logic             ebit,
  input  logic             sa6_valid,
  input  logic [1:0]       sa6_slot,
  input  logic             sa6_bit,
  input  logic             rd_req_valid,
  output logic             rd_req_ready,
  input  logic [SEL_W-1:0] rd_req_sel,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_data
);
  logic [NUM_CNT-1:0] inc, clr, hz;
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic               sa6_a, sa6_b, accept;

  pm_sa6_nibble u_sa6 (
    .clk(clk), .rst_n(rst_n), .enable(e1_mode && mf_ok),
    .bit_valid(sa6_valid), .slot(sa6_slot), .bit_in(sa6_bit),
    .hit_a(sa6_a), .hit_b(sa6_b)
  );

  always_comb begin
    inc[SEL_FRM]  = frame_ok && ((fw_valid && |fw_err) ||
                    (e1_mode && nf_chk_en && nf_valid && !nf_bit2));
    inc[SEL_CRC]  = mf_ok && crc_valid && crc_err;
    inc[SEL_EBIT] = e1_mode && mf_ok && ebit_valid && !ebit;
    inc[SEL_SA6A] = sa6_a;
    inc[SEL_SA6B] = sa6_b;
    hz = '0;
    hz[SEL_EBIT] = !e1_mode;
    hz[SEL_SA6A] = !e1_mode;
    hz[SEL_SA6B] = !e1_mode;
  end

  assign rd_req_ready = !rsp_valid || rsp_ready;
  assign accept       = rd_req_valid && rd_req_ready;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign clr[i] = accept && rd_req_sel == SEL_W'(i);
    pm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hold_zero(hz[i]),
      .inc(inc[i]), .clr(clr[i]), .value(cnt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (32'(rd_req_sel) < NUM_CNT) ? cnt[rd_req_sel] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R3
  frm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_ok && !clr[SEL_FRM]) |=> $stable(cnt[SEL_FRM]));

  // R5
  crc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_ok && !clr[SEL_CRC]) |=> $stable(cnt[SEL_CRC]));

  // R10
  ds1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !e1_mode |=> (cnt[SEL_EBIT] == '0 && cnt[SEL_SA6A] == '0 && cnt[SEL_SA6B] == '0));
endmodule

// File: tb/tb_pm_link_counters.sv
module tb_pm_link_counters;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic e1_mode = 1, nf_chk_en = 0, frame_ok = 1, mf_ok = 1;
  logic fw_valid = 0; logic [6:0] fw_err = 0;
  logic nf_valid = 0, nf_bit2 = 1, crc_valid = 0, crc_err = 0;
  logic ebit_valid = 0, ebit = 1, sa6_valid = 0, sa6_bit = 0;
  logic [1:0] sa6_slot = 0;
  logic rd_req_valid = 0, rsp_ready = 1;
  logic [2:0] rd_req_sel = 0;
  logic rd_req_ready, rsp_valid;
  logic [15:0] rsp_data;

  int checks = 0, fails = 0;
  int model [5];
  int exp_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_link_counters dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bump(int i);
    if (model[i] < 65535) model[i]++;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk("R2 unexpected response", 1, 0);
      else chk(tag_q.pop_front(), int'(rsp_data), exp_q.pop_front());
    end
  end

  task automatic rd(int sel, string tag);
    @(negedge clk);
    rd_req_valid = 1; rd_req_sel = 3'(sel);
    while (!rd_req_ready) @(negedge clk);
    exp_q.push_back(sel < 5 ? model[sel] : 0);
    tag_q.push_back(tag);
    if (sel < 5) model[sel] = 0;
    @(negedge clk);
    rd_req_valid = 0;
  endtask

  task automatic fw(logic [6:0] e);
    @(negedge clk); fw_valid = 1; fw_err = e;
    if (frame_ok && e != 0) bump(0);
    @(negedge clk); fw_valid = 0; fw_err = 0;
  endtask

  task automatic nf(logic b);
    @(negedge clk); nf_valid = 1; nf_bit2 = b;
    if (frame_ok && e1_mode && nf_chk_en && !b) bump(0);
    @(negedge clk); nf_valid = 0; nf_bit2 = 1;
  endtask

  task automatic crc(logic e);
    @(negedge clk); crc_valid = 1; crc_err = e;
    if (mf_ok && e) bump(1);
    @(negedge clk); crc_valid = 0; crc_err = 0;
  endtask

  task automatic eb(logic b);
    @(negedge clk); ebit_valid = 1; ebit = b;
    if (e1_mode && mf_ok && !b) bump(2);
    @(negedge clk); ebit_valid = 0; ebit = 1;
  endtask

  task automatic sa6(logic [3:0] n, int first);
    for (int s = first; s < 4; s++) begin
      @(negedge clk); sa6_valid = 1; sa6_slot = 2'(s); sa6_bit = n[3-s];
    end
    @(negedge clk); sa6_valid = 0;
    if (first == 0 && e1_mode && mf_ok) begin
      if (n[3:2] == 2'b00 && n[0]) bump(3);
      if (n[3:1] == 3'b001) bump(4);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk("watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 rd_req_ready after reset", int'(rd_req_ready), 1);
    for (int i = 0; i < 5; i++) rd(i, "R1 counter zero after reset");

    // R3: one, two, three mismatched bits each count once
    fw(7'b0000001); fw(7'b0000110); fw(7'b1010100); fw(7'b0);
    rd(0, "R3 multi-bit framing word counts once");
    frame_ok = 0; fw(7'b0000011); nf_chk_en = 1; nf(0); frame_ok = 1;
    rd(0, "R3 framing gated by frame alignment");
    // R4
    nf(0); nf(1); nf(0); nf_chk_en = 0; nf(0);
    rd(0, "R4 non-alignment bit2 option");
    // R5
    crc(1); crc(0); crc(1); mf_ok = 0; crc(1); crc(1); mf_ok = 1;
    rd(1, "R5 CRC gated by multiframe alignment");
    // R6
    eb(0); eb(1); eb(0); eb(0); mf_ok = 0; eb(0); mf_ok = 1;
    rd(2, "R6 E-bit zero count");
    // R7
    sa6(4'b0001, 0); sa6(4'b0010, 0); sa6(4'b0011, 0);
    sa6(4'b0101, 0); sa6(4'b1001, 0); sa6(4'b0011, 1);
    mf_ok = 0; sa6(4'b0011, 0); mf_ok = 1;
    rd(3, "R7 Sa6 pattern 00x1"); rd(4, "R7 Sa6 pattern 001x");
    // R2 out-of-range selectors
    crc(1);
    rd(5, "R2 selector 5 reads zero"); rd(7, "R2 selector 7 reads zero");
    rd(1, "R2 counter kept after other reads"); rd(1, "R2 cleared by read");
    // R10
    eb(0); sa6(4'b0001, 0); e1_mode = 0;
    model[2] = 0; model[3] = 0; model[4] = 0;
    eb(0); sa6(4'b0011, 0); nf_chk_en = 1; nf(0); nf_chk_en = 0;
    rd(2, "R10 DS1 E-bit held zero"); rd(3, "R10 DS1 Sa6 held zero");
    rd(0, "R10 DS1 ignores non-alignment bit2");
    e1_mode = 1;
    // R9: event and read on the same edge
    crc(1); crc(1);
    @(negedge clk);
    crc_valid = 1; crc_err = 1; rd_req_valid = 1; rd_req_sel = 3'd1;
    exp_q.push_back(model[1]); tag_q.push_back("R9 read returns old value");
    model[1] = 1;
    @(negedge clk); crc_valid = 0; crc_err = 0; rd_req_valid = 0;
    rd(1, "R9 counter restarts at one");
    // R11: back-pressure
    crc(1);
    @(negedge clk); rsp_ready = 0;
    rd(1, "R11 held response value");
    repeat (3) begin
      @(negedge clk);
      chk("R11 rd_req_ready low while stalled", int'(rd_req_ready), 0);
      chk("R11 rsp_valid held", int'(rsp_valid), 1);
      chk("R11 rsp_data held", int'(rsp_data), 1);
    end
    rsp_ready = 1;
    // R8: saturation
    @(negedge clk); crc_valid = 1; crc_err = 1;
    repeat (65540) @(negedge clk);
    crc_valid = 0; crc_err = 0; model[1] = 65535;
    rd(1, "R8 saturates at 0xFFFF");
    rd(1, "R8 cleared after saturation");
    repeat (4) @(negedge clk);
    chk("R2 all responses seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule